// File: doc/BRIEF.md
# Multi-Queue Cell Overflow Monitor

This block keeps an occupancy count for each of 31 independent cell queues and decides, in the same cycle a cell write arrives, whether that cell may enter its queue. Every queue has its own fill threshold, which is set through a small write port. A write that arrives while a queue is at or above its threshold is still taken, but it sets a sticky per-queue soft-overflow flag. Such writes are allowed up to a fixed margin of seven cells past the threshold. After that, further cells for the queue are dropped, and each drop produces a one-cycle hard-overflow event that carries the queue index.

The flag for a queue clears itself when a successful read brings that queue's occupancy below its threshold. A summary flag is raised while any per-queue flag is set. The per-queue flags are presented as four packed bytes, ready for a register block to read. Cell storage, flow-control generation and the register bus itself sit outside this block. The surrounding queue logic drives the write and read strobes and uses the accept, drop and read-valid answers.

Top module: `cell_ovf_mon`

## Requirements
- R1: After reset every occupancy count and every soft-overflow flag is zero, and every threshold holds its maximum value 2**THR_W-1.
- R2: A write with a queue index below NUM_Q is accepted in the same cycle (wr_accept_o high) when the queue's count is below threshold+MARGIN, and the count then rises by one. A write or read with an index of NUM_Q or more is ignored, with all of wr_accept_o, wr_drop_o and rd_ok_o low.
- R3: A write attempted while the queue's count is at or above its threshold sets that queue's soft-overflow flag at the next clock edge. The cell is still accepted if R2 allows it.
- R4: A write to a queue whose count is at or above threshold+MARGIN (MARGIN=7) is dropped: wr_drop_o is high in the same cycle and wr_accept_o is low. The count does not change.
- R5: One cycle after each dropped write, hard_ovf_o is high for exactly that one cycle, and hard_qid_o carries the index of the queue that dropped the cell.
- R6: A read from a non-empty queue succeeds (rd_ok_o high in the same cycle) and lowers the count by one. A read from an empty queue is ignored: rd_ok_o stays low and the count stays zero.
- R7: A queue's soft-overflow flag is cleared only by a successful read that leaves the count strictly below the threshold. Otherwise the flag is kept.
- R8: A write and a successful read to the same queue in one cycle leave the count unchanged when the write is accepted. The accept/drop decision and the flag update use the count from before that cycle.
- R9: ovf_any_o is high exactly while at least one soft-overflow flag is set.
- R10: The flags appear on ovf_reg_o as packed bytes: byte k, bit j carries queue 8k+j. Queue 0 is bit 0 and queue 30 is bit 30 (byte 3, bit 6), and bit 31 is always zero.
- R11: thr_we_i loads thr_data_i into the threshold of queue thr_qid_i. The new value takes effect from the next cycle, and loading it changes neither the count nor the flag of that queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Cell write attempt |
| wr_qid_i | input | QID_W (5) | Queue index of the write |
| wr_accept_o | output | 1 | Write taken into the queue (same cycle) |
| wr_drop_o | output | 1 | Write discarded (same cycle) |
| rd_valid_i | input | 1 | Cell read attempt |
| rd_qid_i | input | QID_W (5) | Queue index of the read |
| rd_ok_o | output | 1 | Read succeeded, queue was non-empty |
| thr_we_i | input | 1 | Threshold load strobe |
| thr_qid_i | input | QID_W (5) | Queue whose threshold is loaded |
| thr_data_i | input | THR_W (8) | New threshold value |
| ovf_reg_o | output | 8*NUM_REG (32) | Packed soft-overflow flags |
| ovf_any_o | output | 1 | Any soft-overflow flag set |
| hard_ovf_o | output | 1 | One-cycle pulse per dropped cell |
| hard_qid_o | output | QID_W (5) | Queue index of the last dropped cell |

## Verification
The bench builds the block with THR_W=4 and keeps NUM_Q=31 and MARGIN=7. With these values the reset threshold is 15 and the drop point is 22 cells, so filling a queue from reset into hard overflow takes only a few dozen cycles. Smaller loaded thresholds, including zero, reach the soft-overflow set and clear conditions in a handful of cycles. Keeping all 31 queues lets the bench probe the packing of the top byte and the out-of-range index 31.

// File: rtl/cov_pkg.sv
package cov_pkg;
  localparam int unsigned REG_W = 8;

  function automatic int unsigned cdiv(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/cov_q_slot.sv
module cov_q_slot #(
  parameter int unsigned THR_W  = 8,
  parameter int unsigned MARGIN = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hit_i,
  input  logic             rd_hit_i,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             full_o,
  output logic             nonempty_o,
  output logic             ovf_o
);
  localparam int unsigned MAX_CNT = (2 ** THR_W) - 1 + MARGIN;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, thr_ext, limit;
  logic [THR_W-1:0] thr_q;
  logic             ovf_q, ovf_d;
  logic             at_thr, acc, rd_eff, set_ovf, clr_ovf;

  assign thr_ext = CNT_W'(thr_q);
  assign limit   = thr_ext + CNT_W'(MARGIN);
  assign at_thr  = cnt_q >= thr_ext;
  assign full_o  = cnt_q >= limit;
  assign acc     = wr_hit_i & ~full_o;
  assign rd_eff  = rd_hit_i & (cnt_q != '0);

  always_comb begin
    unique case ({acc, rd_eff})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  // set wins; a clear can never coincide with a set on the same queue
  assign set_ovf = wr_hit_i & at_thr;
  assign clr_ovf = rd_eff & (cnt_d < thr_ext);
  always_comb begin
    ovf_d = ovf_q;
    if (clr_ovf) ovf_d = 1'b0;
    if (set_ovf) ovf_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      thr_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      if (thr_we_i) thr_q <= thr_i;
    end
  end

  assign nonempty_o = cnt_q != '0;
  assign ovf_o      = ovf_q;

  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && !full_o && !rd_hit_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && at_thr) |=> ovf_q); // R3
  AST_DROP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && full_o && !rd_hit_i) |=> $stable(cnt_q)); // R4
  AST_EMPTY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_i && !wr_hit_i && cnt_q == '0) |=> (cnt_q == '0)); // R6
  AST_OVF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit_i && !wr_hit_i && cnt_q != '0 && (cnt_q - CNT_W'(1)) < thr_ext) |=> !ovf_q); // R7
  AST_RW_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && rd_hit_i && !full_o && cnt_q != '0) |=> $stable(cnt_q)); // R8
  AST_THR_NO_TOUCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_we_i && !wr_hit_i && !rd_hit_i) |=> ($stable(cnt_q) && $stable(ovf_q))); // R11
endmodule

// File: rtl/cov_lookup.sv
module cov_lookup #(
  parameter int unsigned N     = 31,
  parameter int unsigned IDX_W = 5
) (
  input  logic [N-1:0]     vec_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  localparam int unsigned P = 2 ** IDX_W;
  logic [P-1:0] pad;

  always_comb begin
    pad        = '0;
    pad[N-1:0] = vec_i;
  end

  assign bit_o = pad[idx_i];
endmodule

// File: rtl/cov_pack.sv
module cov_pack #(
  parameter int unsigned N     = 31,
  parameter int unsigned OUT_W = 32
) (
  input  logic [N-1:0]     vec_i,
  output logic [OUT_W-1:0] reg_o
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    if (i < N) begin : g_used
      assign reg_o[i] = vec_i[i];
    end else begin : g_pad
      assign reg_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/cov_hard_evt.sv
module cov_hard_evt #(
  parameter int unsigned QID_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drop_i,
  input  logic [QID_W-1:0] qid_i,
  output logic             pulse_o,
  output logic [QID_W-1:0] qid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o <= 1'b0;
      qid_o   <= '0;
    end else begin
      pulse_o <= drop_i;
      if (drop_i) qid_o <= qid_i;
    end
  end
endmodule

// File: rtl/cell_ovf_mon.sv
module cell_ovf_mon #(
  parameter int unsigned NUM_Q  = 31,
  parameter int unsigned THR_W  = 8,
  parameter int unsigned MARGIN = 7,
  localparam int unsigned QID_W   = $clog2(NUM_Q),
  localparam int unsigned NUM_REG = cov_pkg::cdiv(NUM_Q, cov_pkg::REG_W),
  localparam int unsigned OUT_W   = NUM_REG * cov_pkg::REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [QID_W-1:0] wr_qid_i,
  output logic             wr_accept_o,
  output logic             wr_drop_o,
  input  logic             rd_valid_i,
  input  logic [QID_W-1:0] rd_qid_i,
  output logic             rd_ok_o,
  input  logic             thr_we_i,
  input  logic [QID_W-1:0] thr_qid_i,
  input  logic [THR_W-1:0] thr_data_i,
  output logic [OUT_W-1:0] ovf_reg_o,
  output logic             ovf_any_o,
  output logic             hard_ovf_o,
  output logic [QID_W-1:0] hard_qid_o
);
  localparam logic [QID_W-1:0] LAST_Q = QID_W'(NUM_Q - 1);

  logic [NUM_Q-1:0] wr_hit, rd_hit, thr_hit, full_vec, ne_vec, ovf_vec;
  logic             wr_ok_idx, rd_ok_idx, sel_full, sel_ne;

  assign wr_ok_idx = wr_qid_i <= LAST_Q;
  assign rd_ok_idx = rd_qid_i <= LAST_Q;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign wr_hit[q]  = wr_valid_i & (wr_qid_i  == QID_W'(q));
    assign rd_hit[q]  = rd_valid_i & (rd_qid_i  == QID_W'(q));
    assign thr_hit[q] = thr_we_i   & (thr_qid_i == QID_W'(q));

    cov_q_slot #(.THR_W(THR_W), .MARGIN(MARGIN)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_hit_i   (wr_hit[q]),
      .rd_hit_i   (rd_hit[q]),
      .thr_we_i   (thr_hit[q]),
      .thr_i      (thr_data_i),
      .full_o     (full_vec[q]),
      .nonempty_o (ne_vec[q]),
      .ovf_o      (ovf_vec[q])
    );
  end

  cov_lookup #(.N(NUM_Q), .IDX_W(QID_W)) u_wr_sel (
    .vec_i (full_vec),
    .idx_i (wr_qid_i),
    .bit_o (sel_full)
  );

  cov_lookup #(.N(NUM_Q), .IDX_W(QID_W)) u_rd_sel (
    .vec_i (ne_vec),
    .idx_i (rd_qid_i),
    .bit_o (sel_ne)
  );

  assign wr_accept_o = wr_valid_i & wr_ok_idx & ~sel_full;
  assign wr_drop_o   = wr_valid_i & wr_ok_idx &  sel_full;
  assign rd_ok_o     = rd_valid_i & rd_ok_idx &  sel_ne;

  cov_pack #(.N(NUM_Q), .OUT_W(OUT_W)) u_pack (
    .vec_i (ovf_vec),
    .reg_o (ovf_reg_o)
  );
  assign ovf_any_o = |ovf_vec;

  cov_hard_evt #(.QID_W(QID_W)) u_hard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .drop_i  (wr_drop_o),
    .qid_i   (wr_qid_i),
    .pulse_o (hard_ovf_o),
    .qid_o   (hard_qid_o)
  );

  AST_HARD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_o |=> (hard_ovf_o && hard_qid_o == $past(wr_qid_i))); // R5
  AST_HARD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_drop_o) |=> !hard_ovf_o); // R5
  AST_BAD_QID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_ok_idx) |-> (!wr_accept_o && !wr_drop_o)); // R2
  AST_ANY_ROSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_any_o) |-> $past(wr_valid_i)); // R9
endmodule

// File: tb/tb_cell_ovf_mon.sv
`timescale 1ns/1ps
module tb_cell_ovf_mon;
  localparam int NQ = 31;
  localparam int TW = 4;
  localparam int MG = 7;
  localparam int QW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0, rd_valid = 1'b0, thr_we = 1'b0;
  logic [QW-1:0] wr_qid = '0, rd_qid = '0, thr_qid = '0;
  logic [TW-1:0] thr_data = '0;
  logic          wr_accept, wr_drop, rd_ok, ovf_any, hard_ovf;
  logic [31:0]   ovf_reg;
  logic [QW-1:0] hard_qid;

  always #10 clk = ~clk;

  cell_ovf_mon #(.NUM_Q(NQ), .THR_W(TW), .MARGIN(MG)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_qid_i(wr_qid), .wr_accept_o(wr_accept), .wr_drop_o(wr_drop),
    .rd_valid_i(rd_valid), .rd_qid_i(rd_qid), .rd_ok_o(rd_ok),
    .thr_we_i(thr_we), .thr_qid_i(thr_qid), .thr_data_i(thr_data),
    .ovf_reg_o(ovf_reg), .ovf_any_o(ovf_any), .hard_ovf_o(hard_ovf), .hard_qid_o(hard_qid)
  );

  typedef struct {
    int          due;
    logic [31:0] reg_e;
    logic        any_e;
    logic        hard_e;
    int          qid_e;
    string       tag;
  } item_t;

  item_t sbq[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  int  m_cnt[NQ];
  int  m_thr[NQ];
  bit  m_ovf[NQ];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: registered outputs, one cycle after the stimulus that caused them
  initial forever begin
    @(negedge clk);
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      item_t it;
      it = sbq.pop_front();
      check(it.tag, "ovf_reg", ovf_reg, it.reg_e);
      check(it.tag, "ovf_any", ovf_any, it.any_e);
      check(it.tag, "hard_ovf", hard_ovf, it.hard_e);
      if (it.hard_e) check(it.tag, "hard_qid", hard_qid, it.qid_e);
    end
  end

  task automatic op(bit wv, int wq, bit rv, int rq, bit tw, int tq, int td, string tag);
    bit  wok, rok, e_acc, e_drop, e_rd, setb;
    item_t it;
    @(posedge clk); #1;
    wr_valid = wv; wr_qid = QW'(wq);
    rd_valid = rv; rd_qid = QW'(rq);
    thr_we = tw;   thr_qid = QW'(tq); thr_data = TW'(td);
    wok    = wv && wq < NQ;
    rok    = rv && rq < NQ;
    e_acc  = wok && m_cnt[wq] < m_thr[wq] + MG;
    e_drop = wok && !e_acc;
    e_rd   = rok && m_cnt[rq] > 0;
    setb   = wok && m_cnt[wq] >= m_thr[wq];
    @(negedge clk);
    check(tag, "wr_accept", wr_accept, e_acc);
    check(tag, "wr_drop", wr_drop, e_drop);
    check(tag, "rd_ok", rd_ok, e_rd);
    if (e_acc) m_cnt[wq]++;
    if (e_rd) begin
      m_cnt[rq]--;
      if (m_cnt[rq] < m_thr[rq]) m_ovf[rq] = 1'b0;
    end
    if (setb) m_ovf[wq] = 1'b1;
    if (tw && tq < NQ) m_thr[tq] = td;
    it.due = cyc + 1;
    it.reg_e = '0;
    it.any_e = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      it.reg_e[i] = m_ovf[i];
      it.any_e |= m_ovf[i];
    end
    it.hard_e = e_drop;
    it.qid_e  = wq;
    it.tag    = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(int q, string tag);   op(1, q, 0, 0, 0, 0, 0, tag); endtask
  task automatic rd(int q, string tag);   op(0, 0, 1, q, 0, 0, 0, tag); endtask
  task automatic idle(string tag);        op(0, 0, 0, 0, 0, 0, 0, tag); endtask
  task automatic sthr(int q, int v, string tag); op(0, 0, 0, 0, 1, q, v, tag); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin
      m_cnt[i] = 0; m_thr[i] = (1 << TW) - 1; m_ovf[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, empty queues, flags clear
    idle("R1");
    rd(3, "R1");
    // R1/R3/R4: default threshold 15, fill q3 to 22 then drop
    for (int i = 0; i < 22; i++) wr(3, (i >= 15) ? "R3" : "R1");
    wr(3, "R4");
    wr(3, "R5");
    idle("R5");
    // R6: empty read ignored, then non-empty read
    rd(5, "R6");
    wr(5, "R6");
    rd(5, "R6");
    rd(5, "R6");
    // R11: threshold load together with a write uses the old threshold
    op(1, 7, 0, 0, 1, 7, 2, "R11");
    wr(7, "R11");
    wr(7, "R3");
    for (int i = 0; i < 6; i++) wr(7, "R2");
    wr(7, "R4");
    // R8: read+write same queue while full: drop, count falls
    op(1, 7, 1, 7, 0, 0, 0, "R8");
    op(1, 7, 1, 7, 0, 0, 0, "R8");
    // R7: drain q7, flag kept until count drops below 2
    for (int i = 0; i < 9; i++) rd(7, "R7");
    // R8: at threshold, read+write keeps count, still sets flag
    wr(7, "R8"); wr(7, "R8");
    op(1, 7, 1, 7, 0, 0, 0, "R8");
    rd(7, "R7"); rd(7, "R7");
    // R10: packing of queues 0, 8, 30 with threshold 0
    sthr(0, 0, "R11"); sthr(8, 0, "R11"); sthr(30, 0, "R11");
    wr(0, "R10"); wr(8, "R10"); wr(30, "R10");
    // R2: out-of-range index ignored
    wr(31, "R2");
    rd(31, "R2");
    // R9: clear all flags, summary falls
    sthr(0, 5, "R11"); sthr(8, 5, "R11"); sthr(30, 5, "R11");
    rd(0, "R9"); rd(8, "R9"); rd(30, "R9");
    for (int i = 0; i < 16; i++) rd(3, "R7");
    rd(3, "R9");
    // R2: back-to-back writes to distinct queues
    for (int i = 10; i < 20; i++) wr(i, "R2");
    idle("R9");
    idle("R9");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule